// File: doc/BRIEF.md
# Fused Convolution and Pooling Tile Engine

This block runs one step of a convolutional layer on a square tile of P by P signed 9-bit activations held in a local buffer. The block has one 3x3 kernel of signed 15-bit coefficients and an optional bias. On a start command it evaluates the kernel at every pixel of the tile at once. Neighbours that fall outside the tile count as zero. The block rounds each sum back to the activation scale, applies a saturating ReLU, and then reduces the activation map by 2x2 max pooling with stride 2. The result is a (P/2) by (P/2) tile.

Before a run, a controller writes the tile one element per cycle and the nine taps plus the bias one word per cycle. It then pulses `start`. Two cycles later `done` pulses, and the pooled tile is available on a wide registered output. That output stays unchanged until the next run completes. Writes and starts that arrive while a run is in flight are dropped.

Top module: `convpool_tile`

## Requirements
- R1: While `rst` is high and after it falls, `busy` and `done` are low and every element of `pool_out` is zero until a run completes.
- R2: A tile write stores `tile_wdata` at element (row, col) with `tile_addr` = row*P + col.
- R3: A coefficient write with `coef_idx` = 3*ky + kx (0..8) sets the tap that multiplies the input at (row+ky-1, col+kx-1). Index 9 sets the bias. Indices 10 to 15 change nothing.
- R4: A kernel position that falls outside the tile contributes zero. It never wraps to the opposite edge.
- R5: The block samples `bias_en` with an accepted `start`. When it is 1, the bias is added to every sum. When it is 0, the bias has no effect.
- R6: Each full-precision sum s becomes floor((s + 2^(SHIFT-1)) / 2^SHIFT), which rounds half upward. SHIFT defaults to 6.
- R7: The activation maps negative values to 0 and values above 255 to 255, so every output element lies in 0..255.
- R8: Pooled element (i, j), held at `pool_out[(i*(P/2)+j)*9 +: 9]`, is the maximum of the activations at rows 2i..2i+1 and columns 2j..2j+1.
- R9: `start` is accepted only when `busy` is low. `busy` is then high for exactly two cycles. A `start` seen while `busy` is high is ignored.
- R10: `done` pulses for one cycle in the cycle after `busy` falls. `pool_out` changes only together with that pulse and holds its value otherwise.
- R11: Tile and coefficient writes presented while `busy` is high are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tile_we | input | 1 | Tile element write strobe |
| tile_addr | input | $clog2(P*P) | Tile element index, row*P + col |
| tile_wdata | input | 9 | Signed activation to store |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 4 | Tap index 0..8, bias at 9 |
| coef_wdata | input | 15 | Signed coefficient or bias |
| bias_en | input | 1 | Bias enable, sampled at start |
| start | input | 1 | Begin a run (idle only) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| pool_out | output | (P/2)*(P/2)*9 | Pooled tile, element i*(P/2)+j |

## Verification
The assertions check the control sequence on every cycle: a start seen while idle raises busy, busy lasts exactly two cycles, done is a single pulse that follows busy, the pooled output moves only with done, and no pooled element ever goes negative. The arithmetic can only be shown by the bench's scenarios. These include the tap-to-neighbour mapping, zero padding at all four edges, bias gating, the half-up rounding point, saturation at both ends, and the max selection. The same scenarios show that writes during a run, and writes to unused coefficient indices, leave the results unchanged.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int ACT_W  = 9;
  localparam int COEF_W = 15;
  localparam int NTAP   = 9;
  localparam int ACC_W  = ACT_W + COEF_W + 4;
  localparam int IDX_W  = 4;

  typedef logic signed [ACT_W-1:0]  act_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_POOL = 2'd2
  } cpt_state_t;
endpackage

// File: rtl/cpt_tile_buf.sv
module cpt_tile_buf
  import cpt_pkg::*;
#(
  parameter int P   = 8,
  parameter int TAW = $clog2(P*P)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [TAW-1:0]         addr,
  input  act_t                   wdata,
  output logic [P*P*ACT_W-1:0]   tile_flat
);
  localparam int DEPTH = 2**TAW;

  act_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  for (genvar e = 0; e < P*P; e++) begin : g_out
    assign tile_flat[e*ACT_W +: ACT_W] = mem[e];
  end
endmodule

// File: rtl/cpt_coef_store.sv
module cpt_coef_store
  import cpt_pkg::*;
(
  input  logic                     clk,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  coef_t                    wdata,
  output logic [NTAP*COEF_W-1:0]   taps_flat,
  output coef_t                    bias
);
  coef_t taps [NTAP];
  coef_t bias_r;

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < NTAP; k++) begin
        if (idx == IDX_W'(k)) taps[k] <= wdata;
      end
      if (idx == IDX_W'(NTAP)) bias_r <= wdata;
    end
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_taps
    assign taps_flat[k*COEF_W +: COEF_W] = taps[k];
  end
  assign bias = bias_r;
endmodule

// File: rtl/cpt_pixel_pe.sv
module cpt_pixel_pe
  import cpt_pkg::*;
#(
  parameter int SHIFT = 6
) (
  input  logic [NTAP*ACT_W-1:0]  win,
  input  logic [NTAP*COEF_W-1:0] taps,
  input  coef_t                  bias,
  input  logic                   bias_en,
  output act_t                   act
);
  localparam acc_t RND  = acc_t'(2**(SHIFT-1));
  localparam acc_t AMAX = acc_t'(2**(ACT_W-1) - 1);

  acc_t sum;
  acc_t scaled;

  always_comb begin
    sum = bias_en ? acc_t'(bias) : '0;
    for (int k = 0; k < NTAP; k++) begin
      sum = sum + acc_t'(act_t'(win[k*ACT_W +: ACT_W]))
                * acc_t'(coef_t'(taps[k*COEF_W +: COEF_W]));
    end
  end

  always_comb begin
    scaled = (sum + RND) >>> SHIFT;
    if (scaled < 0)
      act = '0;
    else if (scaled > AMAX)
      act = act_t'(AMAX);
    else
      act = act_t'(scaled[ACT_W-1:0]);
  end
endmodule

// File: rtl/convpool_tile.sv
module convpool_tile
  import cpt_pkg::*;
#(
  parameter int P     = 8,
  parameter int SHIFT = 6,
  localparam int Q    = P / 2,
  localparam int TAW  = $clog2(P*P)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tile_we,
  input  logic [TAW-1:0]         tile_addr,
  input  logic [ACT_W-1:0]       tile_wdata,
  input  logic                   coef_we,
  input  logic [IDX_W-1:0]       coef_idx,
  input  logic [COEF_W-1:0]      coef_wdata,
  input  logic                   bias_en,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic [Q*Q*ACT_W-1:0]   pool_out
);
  cpt_state_t state;
  logic       bias_q;
  logic       done_r;
  logic       idle;

  logic [P*P*ACT_W-1:0]   tile_flat;
  logic [NTAP*COEF_W-1:0] taps_flat;
  coef_t                  bias_val;
  logic [P*P*ACT_W-1:0]   act_all;

  assign idle = (state == ST_IDLE);

  // control sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bias_q <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= (state == ST_POOL);
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_CONV;
          bias_q <= bias_en;
        end
        ST_CONV: state <= ST_POOL;
        ST_POOL: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = !idle;
  assign done = done_r;

  cpt_tile_buf #(.P(P), .TAW(TAW)) u_tile (
    .clk       (clk),
    .we        (tile_we && idle),
    .addr      (tile_addr),
    .wdata     (act_t'(tile_wdata)),
    .tile_flat (tile_flat)
  );

  cpt_coef_store u_coef (
    .clk       (clk),
    .we        (coef_we && idle),
    .idx       (coef_idx),
    .wdata     (coef_t'(coef_wdata)),
    .taps_flat (taps_flat),
    .bias      (bias_val)
  );

  // one processing element per pixel, window built with zero padding
  for (genvar r = 0; r < P; r++) begin : g_row
    for (genvar c = 0; c < P; c++) begin : g_col
      logic [NTAP*ACT_W-1:0] win;
      act_t                  act_w;
      act_t                  act_r;

      for (genvar t = 0; t < NTAP; t++) begin : g_tap
        localparam int NR = r + t / 3 - 1;
        localparam int NC = c + t % 3 - 1;
        if (NR >= 0 && NR < P && NC >= 0 && NC < P) begin : g_in
          assign win[t*ACT_W +: ACT_W] = tile_flat[(NR*P + NC)*ACT_W +: ACT_W];
        end else begin : g_pad
          assign win[t*ACT_W +: ACT_W] = '0;
        end
      end

      cpt_pixel_pe #(.SHIFT(SHIFT)) u_pe (
        .win     (win),
        .taps    (taps_flat),
        .bias    (bias_val),
        .bias_en (bias_q),
        .act     (act_w)
      );

      always_ff @(posedge clk) begin
        if (state == ST_CONV) act_r <= act_w;
      end

      assign act_all[(r*P + c)*ACT_W +: ACT_W] = act_r;
    end
  end

  // 2x2 stride-2 max pooling, registered output
  for (genvar i = 0; i < Q; i++) begin : g_pi
    for (genvar j = 0; j < Q; j++) begin : g_pj
      act_t a00, a01, a10, a11, m_top, m_bot, m_all, pool_r;

      assign a00   = act_t'(act_all[((2*i)*P   + 2*j)*ACT_W   +: ACT_W]);
      assign a01   = act_t'(act_all[((2*i)*P   + 2*j+1)*ACT_W +: ACT_W]);
      assign a10   = act_t'(act_all[((2*i+1)*P + 2*j)*ACT_W   +: ACT_W]);
      assign a11   = act_t'(act_all[((2*i+1)*P + 2*j+1)*ACT_W +: ACT_W]);
      assign m_top = (a00 > a01) ? a00 : a01;
      assign m_bot = (a10 > a11) ? a10 : a11;
      assign m_all = (m_top > m_bot) ? m_top : m_bot;

      always_ff @(posedge clk) begin
        if (rst)                   pool_r <= '0;
        else if (state == ST_POOL) pool_r <= m_all;
      end

      assign pool_out[(i*Q + j)*ACT_W +: ACT_W] = pool_r;
    end
  end
endmodule

// File: rtl/convpool_tile_chk.sv
module convpool_tile_chk
  import cpt_pkg::*;
#(
  parameter int P = 8,
  localparam int Q = P / 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [Q*Q*ACT_W-1:0] pool_out
);
  // R9
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R9
  busy_second_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(pool_out));

  for (genvar k = 0; k < Q*Q; k++) begin : g_sign
    // R7
    nonneg_chk: assert property (@(posedge clk) disable iff (rst)
      !pool_out[(k+1)*ACT_W-1]);
  end
endmodule

bind convpool_tile convpool_tile_chk #(.P(P)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .pool_out (pool_out)
);

// File: tb/convpool_tile_test.sv
module convpool_tile_test;
  localparam int P     = 8;
  localparam int Q     = P / 2;
  localparam int SH    = 6;
  localparam int AW    = 9;
  localparam int CWD   = 15;
  localparam int TAW   = $clog2(P*P);

  logic clk = 1'b0;
  logic rst;
  logic tile_we, coef_we, bias_en, start;
  logic [TAW-1:0]   tile_addr;
  logic [AW-1:0]    tile_wdata;
  logic [3:0]       coef_idx;
  logic [CWD-1:0]   coef_wdata;
  logic             busy, done;
  logic [Q*Q*AW-1:0] pool_out;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  convpool_tile #(.P(P), .SHIFT(SH)) uut (
    .clk(clk), .rst(rst), .tile_we(tile_we), .tile_addr(tile_addr),
    .tile_wdata(tile_wdata), .coef_we(coef_we), .coef_idx(coef_idx),
    .coef_wdata(coef_wdata), .bias_en(bias_en), .start(start),
    .busy(busy), .done(done), .pool_out(pool_out)
  );

  // behavioural reference state
  int m_tile [P*P];
  int m_coef [10];
  int m_pool [Q*Q];
  int m_phase = 0;
  int ph_old;
  bit m_bias  = 0;
  bit m_done  = 0;

  function automatic int sat_act(int s);
    int y;
    y = (s + (1 << (SH-1))) >>> SH;
    if (y < 0) y = 0;
    if (y > 255) y = 255;
    return y;
  endfunction

  task automatic ref_compute();
    int act [P*P];
    for (int r = 0; r < P; r++)
      for (int c = 0; c < P; c++) begin
        int s;
        s = m_bias ? m_coef[9] : 0;
        for (int ky = 0; ky < 3; ky++)
          for (int kx = 0; kx < 3; kx++) begin
            int rr, cc;
            rr = r + ky - 1;
            cc = c + kx - 1;
            if (rr >= 0 && rr < P && cc >= 0 && cc < P)
              s += m_tile[rr*P+cc] * m_coef[ky*3+kx];
          end
        act[r*P+c] = sat_act(s);
      end
    for (int i = 0; i < Q; i++)
      for (int j = 0; j < Q; j++) begin
        int mx;
        mx = act[(2*i)*P + 2*j];
        if (act[(2*i)*P + 2*j+1] > mx)   mx = act[(2*i)*P + 2*j+1];
        if (act[(2*i+1)*P + 2*j] > mx)   mx = act[(2*i+1)*P + 2*j];
        if (act[(2*i+1)*P + 2*j+1] > mx) mx = act[(2*i+1)*P + 2*j+1];
        m_pool[i*Q+j] = mx;
      end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0;
      m_done  = 0;
      for (int k = 0; k < Q*Q; k++) m_pool[k] = 0;
    end else begin
      ph_old = m_phase;
      m_done = 0;
      if (ph_old == 2) begin
        ref_compute();
        m_done  = 1;
        m_phase = 0;
      end else if (ph_old == 1) begin
        m_phase = 2;
      end else begin
        if (tile_we) m_tile[tile_addr] = int'($signed(tile_wdata));
        if (coef_we && coef_idx < 10) m_coef[coef_idx] = int'($signed(coef_wdata));
        if (start) begin
          m_phase = 1;
          m_bias  = bias_en;
        end
      end
    end
  end

  task automatic fail(string req, int act_v, int exp_v, string what);
    n_err++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (busy !== (m_phase != 0)) fail("R9", int'(busy), int'(m_phase != 0), "busy");
      n_chk++;
      if (done !== m_done) fail("R10", int'(done), int'(m_done), "done");
      for (int k = 0; k < Q*Q; k++) begin
        n_chk++;
        if (pool_out[k*AW +: AW] !== AW'(m_pool[k]))
          fail("R8", int'(pool_out[k*AW +: AW]), m_pool[k], "pooled element vs model");
      end
    end
  end

  task automatic chk_all(int v, string req);
    for (int k = 0; k < Q*Q; k++) begin
      n_chk++;
      if (pool_out[k*AW +: AW] !== AW'(v))
        fail(req, int'(pool_out[k*AW +: AW]), v, "pooled element");
    end
  endtask

  task automatic chk_one(int k, int v, string req);
    n_chk++;
    if (pool_out[k*AW +: AW] !== AW'(v))
      fail(req, int'(pool_out[k*AW +: AW]), v, "selected pooled element");
  endtask

  task automatic quiet();
    @(negedge clk);
    tile_we = 0; coef_we = 0; start = 0;
  endtask

  task automatic wr_tile(int a, int v);
    @(negedge clk);
    coef_we = 0; tile_we = 1;
    tile_addr = TAW'(a); tile_wdata = AW'(v);
  endtask

  task automatic wr_coef(int idx, int v);
    @(negedge clk);
    tile_we = 0; coef_we = 1;
    coef_idx = 4'(idx); coef_wdata = CWD'(v);
  endtask

  task automatic fill_tile(int v);
    for (int a = 0; a < P*P; a++) wr_tile(a, v);
    quiet();
  endtask

  task automatic set_kernel(int v, int bias);
    for (int t = 0; t < 9; t++) wr_coef(t, v);
    wr_coef(9, bias);
    quiet();
  endtask

  task automatic run(bit be);
    @(negedge clk);
    tile_we = 0; coef_we = 0; bias_en = be; start = 1;
    @(negedge clk);
    start = 0;
    for (int w = 0; w < 10 && !done; w++) @(negedge clk);
    n_chk++;
    if (!done) fail("R10", 0, 1, "done pulse after start");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog: actual 0 expected 1 run completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int dn;
    rst = 1; tile_we = 0; coef_we = 0; bias_en = 0; start = 0;
    tile_addr = '0; tile_wdata = '0; coef_idx = '0; coef_wdata = '0;
    for (int k = 0; k < P*P; k++) m_tile[k] = 0;
    for (int k = 0; k < 10; k++) m_coef[k] = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    n_chk++; if (busy !== 1'b0) fail("R1", int'(busy), 0, "busy in reset");
    n_chk++; if (done !== 1'b0) fail("R1", int'(done), 0, "done in reset");
    chk_all(0, "R1");
    rst = 0;
    @(negedge clk);
    chk_all(0, "R1");

    // R2/R3: tap 0 reads (r-1,c-1); single value at (2,3) lands at act (3,4)
    fill_tile(0);
    set_kernel(0, 0);
    wr_coef(0, 64); quiet();
    wr_tile(2*P+3, 100); quiet();
    run(0);
    chk_one(1*Q+2, 100, "R2");
    chk_one(0, 0, "R3");

    // R4: corner values must not wrap across the tile edge
    fill_tile(0);
    wr_tile(P*P-1, 100); quiet();
    run(0);
    chk_all(0, "R4");
    wr_tile(P*P-1, 0); wr_tile(0, 100);
    wr_coef(0, 0); wr_coef(8, 64); quiet();
    run(0);
    chk_all(0, "R4");

    // R5: bias gating
    fill_tile(7);
    set_kernel(0, 640);
    run(1);
    chk_all(10, "R5");
    run(0);
    chk_all(0, "R5");

    // R6: rounding half upward
    set_kernel(0, 0);
    wr_coef(4, 1); quiet();
    fill_tile(32);
    run(0);
    chk_all(1, "R6");
    fill_tile(31);
    run(0);
    chk_all(0, "R6");
    fill_tile(96);
    run(0);
    chk_all(2, "R6");

    // R3: unused coefficient indices change nothing
    wr_coef(10, 16383); wr_coef(15, 16383); quiet();
    fill_tile(32);
    run(0);
    chk_all(1, "R3");

    // R11: writes during a run are dropped
    @(negedge clk); bias_en = 0; start = 1;
    @(negedge clk); start = 0;
    tile_we = 1; tile_addr = '0; tile_wdata = AW'(200);
    coef_we = 1; coef_idx = 4'd4; coef_wdata = CWD'(5000);
    @(negedge clk); tile_addr = TAW'(9);
    @(negedge clk); tile_we = 0; coef_we = 0;
    n_chk++; if (!done) fail("R10", 0, 1, "done two cycles after busy rise");
    chk_all(1, "R11");
    run(0);
    chk_all(1, "R11");

    // R7: saturation at both ends
    fill_tile(255);
    set_kernel(16383, 0);
    run(0);
    chk_all(255, "R7");
    set_kernel(-100, 0);
    run(0);
    chk_all(0, "R7");

    // R9: start held into the busy period gives a single run
    @(negedge clk); start = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    dn = 0;
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      if (done) dn++;
    end
    n_chk++;
    if (dn != 1) fail("R9", dn, 1, "done pulses for held start");

    // R8: random tiles and kernels against the reference
    for (int n = 0; n < 6; n++) begin
      for (int a = 0; a < P*P; a++) wr_tile(a, int'($urandom_range(0, 511)) - 256);
      for (int t = 0; t < 10; t++) wr_coef(t, int'($urandom_range(0, 4000)) - 2000);
      quiet();
      run(n % 2 == 0);
      for (int k = 0; k < Q*Q; k++) begin
        n_chk++;
        if (pool_out[k*AW +: AW] !== AW'(m_pool[k]))
          fail("R8", int'(pool_out[k*AW +: AW]), m_pool[k], "random pooled element");
      end
    end

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule